// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from peripherals into a sticky status register and gates them with a mask register. The CPU raises or lowers one interrupt line from the two registers. Both registers sit on a small register bus. The status register is at offset 0x70 and the mask register is at offset 0x74. Both accept 16-bit and 32-bit writes.

Peripherals have two ways to set status bits. A one-cycle request pulse sets a bit at once. A level source is only sampled when software acknowledges. The CPU acknowledges by writing the status register. The stored value is then ANDed with the written data and also with the current mask, so a single access clears both the written zeros and any bits the mask disables. Two level sources, the serial port on bit 7 and the sound unit on bit 9, are ORed back into status just before that AND. If either is still asserting, its bit therefore survives the acknowledge. Bit 3 carries the DMA request.

The CPU interrupt line is a registered OR over status AND mask. It changes on the same edge as the register that caused the change.

Top module: `irq_stat_mask_ctl`

## Requirements
- R1: On reset, both registers read zero and `cpu_irq` is low.
- R2: A high bit on `req_pulse` sets the same status bit at the next clock edge. Without a status write, a set status bit never clears.
- R3: A 32-bit write to offset 0x70 makes status equal to old status AND mask AND write data.
- R4: A 16-bit write (`bus_wide`=0) changes only bits 15:0 of the addressed register. Bits 31:16 keep their value.
- R5: A write to offset 0x74 stores the write data in the mask unchanged, and the mask reads back that value.
- R6: After every clock edge, `cpu_irq` equals the OR-reduction of (status AND mask) as they stand after that edge.
- R7: A mask write that enables a pending status bit raises `cpu_irq` on the same edge that updates the mask. A mask write that disables every pending bit lowers it on that edge.
- R8: During a status write, a level source that is high sets its bit before the acknowledge AND. This applies to bit 7 (serial) and bit 9 (sound).
- R9: A request pulse in the same cycle as a status write that would clear that bit wins, so the bit stays set.
- R10: Reads from any offset other than 0x70 or 0x74 return zero. Writes to those offsets change neither register.
- R11: Level lines have no effect outside a status write, and level lines other than bits 7 and 9 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | 32 | Peripheral request pulses, one per status bit |
| req_level | input | 32 | Level-held sources; only bits 7 and 9 are used |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access (bits 15:0) |
| bus_rdata | output | 32 | Read data of the addressed register |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench first acknowledges with data that keeps a bit while the mask has that bit off. A design that ANDs with the data alone would leave that bit stuck. It then drives a request pulse into an acknowledge that would clear that bit. A design that gives the write priority would lose the interrupt. It writes 16-bit values over nonzero upper halves, which catches a design that zero-fills or overwrites bits 31:16. It also drives the level sources outside a write, and drives a level line other than bits 7 and 9. A design that treats level lines as pulses, or that accepts any level bit, would set status where it must stay clear.

// File: rtl/isc_pkg.sv
package isc_pkg;
  parameter int REG_W  = 32;
  parameter int HALF_W = REG_W / 2;

  // Lanes touched by an access: low half for a 16-bit access, all bits otherwise.
  function automatic logic [REG_W-1:0] lane_mask(input logic wide);
    lane_mask = wide ? {REG_W{1'b1}} : {{(REG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  endfunction

  // Acknowledge arithmetic: level refresh, then AND with mask and data on the written lanes.
  // Same-cycle pulses are ORed in last so they survive.
  function automatic logic [REG_W-1:0] status_next(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] pulses,
    input logic [REG_W-1:0] levels,
    input logic [REG_W-1:0] msk,
    input logic [REG_W-1:0] data,
    input logic [REG_W-1:0] lanes,
    input logic             ack);
    logic [REG_W-1:0] t;
    t = old_v;
    if (ack) begin
      t = old_v | levels;
      t = (t & ~lanes) | (t & msk & data & lanes);
    end
    status_next = t | pulses;
  endfunction

  function automatic logic [REG_W-1:0] mask_next(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] data,
    input logic [REG_W-1:0] lanes,
    input logic             wr);
    mask_next = wr ? ((old_v & ~lanes) | (data & lanes)) : old_v;
  endfunction
endpackage

// File: rtl/isc_decode.sv
module isc_decode #(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic                     wide,
  output logic                     sel_stat,
  output logic                     sel_mask,
  output logic                     wr_stat,
  output logic                     wr_mask,
  output logic [isc_pkg::REG_W-1:0] lanes
);
  always_comb begin
    sel_stat = (addr == STAT_OFS);
    sel_mask = (addr == MASK_OFS);
    wr_stat  = we && sel_stat;
    wr_mask  = we && sel_mask;
    lanes    = isc_pkg::lane_mask(wide);
  end

  always_comb begin
    a_one_target_r10: assert (!(wr_stat && wr_mask));
  end
endmodule

// File: rtl/isc_status.sv
module isc_status #(
  parameter logic [isc_pkg::REG_W-1:0] LVL_BITS = 32'h0000_0280
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [isc_pkg::REG_W-1:0] req_pulse,
  input  logic [isc_pkg::REG_W-1:0] req_level,
  input  logic [isc_pkg::REG_W-1:0] mask_q,
  input  logic [isc_pkg::REG_W-1:0] wdata,
  input  logic [isc_pkg::REG_W-1:0] lanes,
  input  logic                      wr_stat,
  output logic [isc_pkg::REG_W-1:0] stat_d,
  output logic [isc_pkg::REG_W-1:0] stat_q
);
  localparam int W = isc_pkg::REG_W;
  logic [W-1:0] lvl_eff;

  assign lvl_eff = req_level & LVL_BITS;

  always_comb
    stat_d = isc_pkg::status_next(stat_q, req_pulse, lvl_eff, mask_q, wdata, lanes, wr_stat);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_pulse_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_pulse) |=> ((stat_q & $past(req_pulse)) == $past(req_pulse)));
  p_ack_no_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & ~($past(stat_q) | $past(lvl_eff) | $past(req_pulse))) == '0));
  p_ack_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !lanes[W-1] && !(|req_pulse)) |=> (stat_q[W-1:W/2] == $past(stat_q[W-1:W/2])));
endmodule

// File: rtl/isc_mask.sv
module isc_mask (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [isc_pkg::REG_W-1:0] wdata,
  input  logic [isc_pkg::REG_W-1:0] lanes,
  input  logic                      wr_mask,
  output logic [isc_pkg::REG_W-1:0] mask_d,
  output logic [isc_pkg::REG_W-1:0] mask_q
);
  localparam int W = isc_pkg::REG_W;

  always_comb mask_d = isc_pkg::mask_next(mask_q, wdata, lanes, wr_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  p_mask_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !lanes[W-1]) |=> (mask_q[W-1:W/2] == $past(mask_q[W-1:W/2])));
  p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && lanes[W-1]) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/isc_irq.sv
module isc_irq (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [isc_pkg::REG_W-1:0] stat_d,
  input  logic [isc_pkg::REG_W-1:0] mask_d,
  input  logic [isc_pkg::REG_W-1:0] stat_q,
  input  logic [isc_pkg::REG_W-1:0] mask_q,
  output logic                      irq_q
);
  logic irq_d;
  assign irq_d = |(stat_d & mask_d);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;

  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == |(stat_q & mask_q));
endmodule

// File: rtl/irq_stat_mask_ctl.sv
module irq_stat_mask_ctl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74,
  parameter logic [31:0] LVL_BITS = 32'h0000_0280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       req_pulse,
  input  logic [31:0]       req_level,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_wide,
  output logic [31:0]       bus_rdata,
  output logic              cpu_irq
);
  localparam int W = isc_pkg::REG_W;

  logic         sel_stat, sel_mask, wr_stat, wr_mask;
  logic [W-1:0] lanes, stat_d, stat_q, mask_d, mask_q;

  isc_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)) u_dec (
    .addr(bus_addr), .we(bus_we), .wide(bus_wide),
    .sel_stat(sel_stat), .sel_mask(sel_mask),
    .wr_stat(wr_stat), .wr_mask(wr_mask), .lanes(lanes));

  isc_status #(.LVL_BITS(LVL_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_level(req_level),
    .mask_q(mask_q), .wdata(bus_wdata), .lanes(lanes), .wr_stat(wr_stat),
    .stat_d(stat_d), .stat_q(stat_q));

  isc_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata), .lanes(lanes),
    .wr_mask(wr_mask), .mask_d(mask_d), .mask_q(mask_q));

  isc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .stat_d(stat_d), .mask_d(mask_d),
    .stat_q(stat_q), .mask_q(mask_q), .irq_q(cpu_irq));

  always_comb begin
    if (sel_stat)      bus_rdata = stat_q;
    else if (sel_mask) bus_rdata = mask_q;
    else               bus_rdata = '0;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (stat_q == '0 && mask_q == '0 && !cpu_irq));
  p_other_ofs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !sel_stat && !sel_mask && !(|req_pulse)) |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

// File: tb/sim_irq_stat_mask_ctl.sv
`timescale 1ns/100ps
module sim_irq_stat_mask_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_pulse = '0, req_level = '0, bus_wdata = '0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0, bus_wide = 1'b1;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_stat_mask_ctl u0 (.clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_level(req_level),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  typedef struct packed {
    logic [7:0]  addr; logic we; logic wide;
    logic [31:0] wdata, pulse, level, e_stat, e_mask;
    logic        e_irq; logic [7:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{8'h00,1'b0,1'b1,32'h0,         32'h0000_0008,32'h0,         32'h0000_0008,32'h0,         1'b0,8'd2},  // R2
    '{8'h00,1'b0,1'b1,32'h0,         32'h0001_0000,32'h0,         32'h0001_0008,32'h0,         1'b0,8'd2},  // R2
    '{8'h74,1'b1,1'b1,32'h0000_0008, 32'h0,        32'h0,         32'h0001_0008,32'h0000_0008,1'b1,8'd7},  // R7
    '{8'h70,1'b1,1'b1,32'hFFFF_FFFF, 32'h0,        32'h0,         32'h0000_0008,32'h0000_0008,1'b1,8'd3},  // R3 masked bit acked
    '{8'h70,1'b1,1'b1,32'hFFFF_FFF7, 32'h0,        32'h0,         32'h0,        32'h0000_0008,1'b0,8'd3},  // R3
    '{8'h74,1'b1,1'b0,32'hABCD_0280, 32'h0,        32'h0,         32'h0,        32'h0000_0280,1'b0,8'd4},  // R4
    '{8'h74,1'b1,1'b1,32'hFFFF_0280, 32'h0,        32'h0,         32'h0,        32'hFFFF_0280,1'b0,8'd5},  // R5
    '{8'h74,1'b1,1'b0,32'h1234_0288, 32'h0,        32'h0,         32'h0,        32'hFFFF_0288,1'b0,8'd4},  // R4
    '{8'h00,1'b0,1'b1,32'h0,         32'h8001_0008,32'h0,         32'h8001_0008,32'hFFFF_0288,1'b1,8'd6},  // R6
    '{8'h70,1'b1,1'b0,32'h0,         32'h0,        32'h0,         32'h8001_0000,32'hFFFF_0288,1'b1,8'd4},  // R4
    '{8'h70,1'b1,1'b1,32'h7FFF_FFFF, 32'h0,        32'h0,         32'h0001_0000,32'hFFFF_0288,1'b1,8'd3},  // R3
    '{8'h70,1'b1,1'b1,32'hFFFF_FFFF, 32'h0,        32'h0000_0280, 32'h0001_0280,32'hFFFF_0288,1'b1,8'd8},  // R8
    '{8'h70,1'b1,1'b1,32'h0,         32'h0,        32'h0,         32'h0,        32'hFFFF_0288,1'b0,8'd3},  // R3
    '{8'h00,1'b0,1'b1,32'h0,         32'h0,        32'h0000_0280, 32'h0,        32'hFFFF_0288,1'b0,8'd11}, // R11
    '{8'h70,1'b1,1'b1,32'hFFFF_FFFF, 32'h0,        32'h0000_0400, 32'h0,        32'hFFFF_0288,1'b0,8'd11}, // R11
    '{8'h70,1'b1,1'b1,32'h0,         32'h0000_0008,32'h0,         32'h0000_0008,32'hFFFF_0288,1'b1,8'd9},  // R9
    '{8'h78,1'b1,1'b1,32'hFFFF_FFFF, 32'h0,        32'h0,         32'h0000_0008,32'hFFFF_0288,1'b1,8'd10}, // R10
    '{8'h70,1'b1,1'b1,32'hFFFF_FFFF, 32'h0,        32'h0000_0080, 32'h0000_0088,32'hFFFF_0288,1'b1,8'd8}   // R8
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic we, input logic wide,
                       input logic [31:0] d, input logic [31:0] p, input logic [31:0] l);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wide = wide; bus_wdata = d; req_pulse = p; req_level = l;
    @(posedge clk);
    #0.5;
    bus_we = 1'b0; req_pulse = '0; req_level = '0;
  endtask

  task automatic observe(input string req, input logic [31:0] es, input logic [31:0] em, input logic ei);
    bus_addr = 8'h70; #0.3; check(req, "status", bus_rdata, es);
    bus_addr = 8'h74; #0.3; check(req, "mask",   bus_rdata, em);
    check(req, "cpu_irq", {31'b0, cpu_irq}, {31'b0, ei});
  endtask

  initial begin
    #(4.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    observe("R1", 32'h0, 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    observe("R1", 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].addr, VT[i].we, VT[i].wide, VT[i].wdata, VT[i].pulse, VT[i].level);
      observe($sformatf("R%0d", VT[i].req), VT[i].e_stat, VT[i].e_mask, VT[i].e_irq);
    end

    // R10: unmapped read returns zero while status is nonzero
    bus_addr = 8'h7C; #0.3;
    check("R10", "unmapped read", bus_rdata, 32'h0);

    // R7: clearing the mask drops the line on the same edge, re-enabling bit7 raises it
    apply(8'h74, 1'b1, 1'b1, 32'h0, 32'h0, 32'h0);
    observe("R7", 32'h0000_0088, 32'h0, 1'b0);
    apply(8'h74, 1'b1, 1'b1, 32'h0000_0080, 32'h0, 32'h0);
    observe("R7", 32'h0000_0088, 32'h0000_0080, 1'b1);

    // R1: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0; #0.5;
    observe("R1", 32'h0, 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule